// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog peripheral that sits on a simple 32-bit register bus. A programmable prescaler followed by a selectable power-of-two divider slows the system clock to a tick, and each tick moves a 16-bit down-counter one step. When a tick finds the counter at zero, the counter reloads from a data register and an expiry event is produced. Depending on two enable bits, that event sets a sticky level interrupt, emits a single-cycle system reset request, or both.

Software programs the reload value and the starting count, then sets the run bit. Writing the count register at any time restarts the countdown from the written value; this is the keepalive. A separate write-only register acknowledges the interrupt. Prescaler and divider changes made while the timer runs are picked up at the next prescaler wrap, so a period never runs with a torn setting.

Top module: `wdog_prescaled`

## Requirements
- R1: After reset the control register reads 0, the reload and count registers read 0x8000, and both irq_o and sys_rst_req_o are low.
- R2: Registers sit at byte offsets 0x0 (control), 0x4 (reload), 0x8 (count), 0xC (interrupt clear). Control bit 0 enables the reset request, bit 2 enables the interrupt, bits [4:3] select the divider, bit 5 runs the timer, bits [15:8] hold the prescale value; every other control bit reads 0, and the reload and count registers read back their low 16 bits.
- R3: While the run bit is set, a tick occurs every (prescale+1) x (16 << divider select) clock cycles, counted from the edge that sets the run bit, and each tick lowers a non-zero count by one.
- R4: A tick that finds the count at zero reloads the count from the reload register and produces one expiry event.
- R5: With the interrupt enable set, an expiry sets irq_o, which stays high until any value is written to the interrupt-clear register; a clear takes effect on the following edge.
- R6: With the reset enable set, an expiry drives sys_rst_req_o high for exactly one clock cycle.
- R7: With both enables set, one expiry sets irq_o and pulses sys_rst_req_o on the same cycle.
- R8: A write to the count register loads the written value and overrides any tick at the same edge, so periodic writes keep the timer from expiring.
- R9: Reads of the interrupt-clear register return 0.
- R10: Clearing the run bit freezes the count and returns the prescaler and divider to their start, so a restart waits a full period for its first tick.
- R11: A prescale or divider write made while running takes effect at the next prescaler wrap.
- R12: With neither enable set, an expiry still reloads the count but leaves irq_o and sys_rst_req_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Bus access strobe for this cycle |
| bus_we_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | 4 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Sticky expiry interrupt |
| sys_rst_req_o | output | 1 | One-cycle reset request on expiry |

## Verification
The bench builds the block with its default parameters: 16-bit counter, 8-bit prescale field, a 2-bit divider select and a base division of 16. Running mostly with prescale 0 and divider select 0 gives a 16-cycle tick, so expiry, reload, keepalive and the freeze-and-restart behaviour are all reached within a few hundred cycles, while short runs with prescale 1 and 3 and divider select 1 exercise the period formula and the deferred pickup of new settings at a prescaler wrap.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   // register word index (byte address bits [3:2])
   localparam int unsigned IDX_CTRL  = 0;
   localparam int unsigned IDX_RELD  = 1;
   localparam int unsigned IDX_COUNT = 2;
   localparam int unsigned IDX_ICLR  = 3;

   // control field positions
   localparam int unsigned POS_RST_EN = 0;
   localparam int unsigned POS_IRQ_EN = 2;
   localparam int unsigned POS_DIV    = 3;
   localparam int unsigned POS_RUN    = 5;
   localparam int unsigned POS_PRE    = 8;

   typedef struct packed {
      logic run;
      logic irq_en;
      logic rst_en;
   } wdog_en_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned PRE_W    = 8,
   parameter int unsigned DSEL_W   = 2,
   parameter int unsigned CNT_INIT = 16'h8000
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_en_i,
   input  logic              bus_we_i,
   input  logic [3:0]        bus_addr_i,
   input  logic [31:0]       bus_wdata_i,
   output logic [31:0]       bus_rdata_o,
   input  logic [CNT_W-1:0]  cnt_i,
   output wdog_en_t          en_o,
   output logic [PRE_W-1:0]  pre_o,
   output logic [DSEL_W-1:0] dsel_o,
   output logic [CNT_W-1:0]  reld_o,
   output logic              cnt_wr_o,
   output logic [CNT_W-1:0]  cnt_wdata_o,
   output logic              clr_o
);
   logic       wr;
   logic [1:0] widx;
   logic       unused_ok;

   assign wr   = bus_en_i & bus_we_i;
   assign widx = bus_addr_i[3:2];
   assign unused_ok = &{1'b0, bus_addr_i[1:0], bus_wdata_i};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_o   <= '0;
         pre_o  <= '0;
         dsel_o <= '0;
         reld_o <= CNT_W'(CNT_INIT);
      end else if (wr) begin
         if (widx == 2'(IDX_CTRL)) begin
            en_o.run    <= bus_wdata_i[POS_RUN];
            en_o.irq_en <= bus_wdata_i[POS_IRQ_EN];
            en_o.rst_en <= bus_wdata_i[POS_RST_EN];
            pre_o       <= bus_wdata_i[POS_PRE +: PRE_W];
            dsel_o      <= bus_wdata_i[POS_DIV +: DSEL_W];
         end
         if (widx == 2'(IDX_RELD))
            reld_o <= bus_wdata_i[CNT_W-1:0];
      end
   end

   assign cnt_wr_o    = wr && (widx == 2'(IDX_COUNT));
   assign cnt_wdata_o = bus_wdata_i[CNT_W-1:0];
   assign clr_o       = wr && (widx == 2'(IDX_ICLR));

   always_comb begin
      bus_rdata_o = '0;
      unique case (widx)
         2'(IDX_CTRL): begin
            bus_rdata_o[POS_RUN]           = en_o.run;
            bus_rdata_o[POS_IRQ_EN]        = en_o.irq_en;
            bus_rdata_o[POS_RST_EN]        = en_o.rst_en;
            bus_rdata_o[POS_PRE +: PRE_W]  = pre_o;
            bus_rdata_o[POS_DIV +: DSEL_W] = dsel_o;
         end
         2'(IDX_RELD):  bus_rdata_o[CNT_W-1:0] = reld_o;
         2'(IDX_COUNT): bus_rdata_o[CNT_W-1:0] = cnt_i;
         default:       bus_rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/wdog_tickgen.sv
module wdog_tickgen #(
   parameter int unsigned PRE_W    = 8,
   parameter int unsigned DSEL_W   = 2,
   parameter int unsigned DIV_LOG2 = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              run_i,
   input  logic [PRE_W-1:0]  pre_i,
   input  logic [DSEL_W-1:0] dsel_i,
   output logic              tick_o
);
   localparam int unsigned DC_W = DIV_LOG2 + (1 << DSEL_W) - 1;

   logic [PRE_W-1:0]  pcnt, pre_act;
   logic [DSEL_W-1:0] dsel_act;
   logic [DC_W-1:0]   dcnt, dlim;
   logic [DC_W:0]     span;
   logic              pwrap, dwrap;

   assign span   = (DC_W+1)'(1) << (DIV_LOG2 + int'(dsel_act));
   assign dlim   = DC_W'(span - (DC_W+1)'(1));
   assign pwrap  = (pcnt == pre_act);
   assign dwrap  = (dcnt >= dlim);
   assign tick_o = run_i & pwrap & dwrap;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pcnt     <= '0;
         dcnt     <= '0;
         pre_act  <= '0;
         dsel_act <= '0;
      end else if (!run_i) begin
         pcnt     <= '0;
         dcnt     <= '0;
         pre_act  <= pre_i;
         dsel_act <= dsel_i;
      end else if (pwrap) begin
         pcnt     <= '0;
         dcnt     <= dwrap ? '0 : dcnt + 1'b1;
         pre_act  <= pre_i;
         dsel_act <= dsel_i;
      end else begin
         pcnt <= pcnt + 1'b1;
      end
   end

   // ticks are at least 16 cycles apart
   assert_tick_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);
   // a stopped timer cannot tick on the next cycle, even if restarted
   assert_stop_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> !tick_o);
endmodule

// File: rtl/wdog_expiry.sv
module wdog_expiry #(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned CNT_INIT = 16'h8000
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             cnt_wr_i,
   input  logic [CNT_W-1:0] cnt_wdata_i,
   input  logic [CNT_W-1:0] reld_i,
   input  logic             irq_en_i,
   input  logic             rst_en_i,
   input  logic             clr_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             irq_o,
   output logic             rst_req_o
);
   logic at_zero, fire;

   assign at_zero = (cnt_o == '0);
   assign fire    = tick_i & at_zero & ~cnt_wr_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_o     <= CNT_W'(CNT_INIT);
         irq_o     <= 1'b0;
         rst_req_o <= 1'b0;
      end else begin
         if (cnt_wr_i)    cnt_o <= cnt_wdata_i;
         else if (tick_i) cnt_o <= at_zero ? reld_i : cnt_o - 1'b1;

         if (fire && irq_en_i) irq_o <= 1'b1;
         else if (clr_i)       irq_o <= 1'b0;

         rst_req_o <= fire & rst_en_i;
      end
   end

   assert_rst_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_req_o |=> !rst_req_o);
   assert_irq_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o) |-> $past(tick_i && irq_en_i));
   assert_irq_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(irq_o) |-> $past(clr_i));
   assert_cnt_move_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(cnt_o) |-> $past(tick_i || cnt_wr_i));
endmodule

// File: rtl/wdog_prescaled.sv
module wdog_prescaled
   import wdog_pkg::*;
#(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned PRE_W    = 8,
   parameter int unsigned DSEL_W   = 2,
   parameter int unsigned DIV_LOG2 = 4,
   parameter int unsigned CNT_INIT = 16'h8000
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        bus_en_i,
   input  logic        bus_we_i,
   input  logic [3:0]  bus_addr_i,
   input  logic [31:0] bus_wdata_i,
   output logic [31:0] bus_rdata_o,
   output logic        irq_o,
   output logic        sys_rst_req_o
);
   initial begin
      assert (CNT_W >= 2 && CNT_W <= 32);
      assert (PRE_W >= 1 && POS_PRE + PRE_W <= 32);
      assert (DSEL_W >= 1 && POS_DIV + DSEL_W <= POS_RUN);
      assert (CNT_INIT < (64'd1 << CNT_W));
   end

   wdog_en_t          en;
   logic [PRE_W-1:0]  pre;
   logic [DSEL_W-1:0] dsel;
   logic [CNT_W-1:0]  reld, cnt, cnt_wdata;
   logic              cnt_wr, clr, tick;

   wdog_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W), .DSEL_W(DSEL_W), .CNT_INIT(CNT_INIT)) u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .bus_en_i(bus_en_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
      .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
      .cnt_i(cnt), .en_o(en), .pre_o(pre), .dsel_o(dsel), .reld_o(reld),
      .cnt_wr_o(cnt_wr), .cnt_wdata_o(cnt_wdata), .clr_o(clr)
   );

   wdog_tickgen #(.PRE_W(PRE_W), .DSEL_W(DSEL_W), .DIV_LOG2(DIV_LOG2)) u_tick (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(en.run),
      .pre_i(pre), .dsel_i(dsel), .tick_o(tick)
   );

   wdog_expiry #(.CNT_W(CNT_W), .CNT_INIT(CNT_INIT)) u_exp (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
      .cnt_wr_i(cnt_wr), .cnt_wdata_i(cnt_wdata), .reld_i(reld),
      .irq_en_i(en.irq_en), .rst_en_i(en.rst_en), .clr_i(clr),
      .cnt_o(cnt), .irq_o(irq_o), .rst_req_o(sys_rst_req_o)
   );

   // a stopped timer never moves its count without a bus write
   assert_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en.run && !cnt_wr) |=> $stable(cnt));
endmodule

// File: tb/wdog_prescaled_tb.sv
`timescale 1ns/1ps
module wdog_prescaled_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0, we = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq, rreq;

   int checks = 0, errors = 0, cyc = 0;

   always #2.5 clk = ~clk;

   wdog_prescaled u_dut (
      .clk_i(clk), .rst_ni(rst_n), .bus_en_i(en), .bus_we_i(we),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .irq_o(irq), .sys_rst_req_o(rreq)
   );

   // ---------------- behavioural reference model ----------------
   int unsigned m_ctrl, m_reld, m_cnt;
   int unsigned m_pc, m_dc, m_pre_a, m_div_a;
   bit          m_irq, m_rst;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctrl = 0; m_reld = 32'h8000; m_cnt = 32'h8000;
         m_pc = 0; m_dc = 0; m_pre_a = 0; m_div_a = 0;
         m_irq = 0; m_rst = 0;
      end else begin
         bit tick, fire, wr;
         int unsigned w;
         wr = en && we; w = addr >> 2;
         tick = 0;
         if (m_ctrl[5]) begin
            if (m_pc == m_pre_a) begin
               m_pc = 0;
               if (m_dc + 1 >= (16 << m_div_a)) begin m_dc = 0; tick = 1; end
               else m_dc = m_dc + 1;
               m_pre_a = (m_ctrl >> 8) & 255; m_div_a = (m_ctrl >> 3) & 3;
            end else m_pc = m_pc + 1;
         end else begin
            m_pc = 0; m_dc = 0;
            m_pre_a = (m_ctrl >> 8) & 255; m_div_a = (m_ctrl >> 3) & 3;
         end
         fire = tick && (m_cnt == 0) && !(wr && w == 2);
         if (wr && w == 2) m_cnt = wdata & 16'hFFFF;
         else if (tick) m_cnt = (m_cnt == 0) ? m_reld : m_cnt - 1;
         if (fire && m_ctrl[2]) m_irq = 1;
         else if (wr && w == 3) m_irq = 0;
         m_rst = fire && m_ctrl[0];
         if (wr && w == 0) m_ctrl = wdata & 32'h0000FF3D;
         if (wr && w == 1) m_reld = wdata & 16'hFFFF;
      end
   end

   function automatic int unsigned model_read(input logic [3:0] a);
      case (a >> 2)
         0: return m_ctrl;
         1: return m_reld;
         2: return m_cnt;
         default: return 0;
      endcase
   endfunction

   // ---------------- cycle compare and observers ----------------
   int  rst_pulses = 0, rst_width = 0, rst_wmax = 0;
   bit  both_seen = 0, irq_prev = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         checks += 2;
         if (irq !== m_irq) begin
            errors++; $display("FAIL R5 irq_o cycle %0d: got %0b exp %0b", cyc, irq, m_irq);
         end
         if (rreq !== m_rst) begin
            errors++; $display("FAIL R6 sys_rst_req_o cycle %0d: got %0b exp %0b", cyc, rreq, m_rst);
         end
         if (rreq) begin rst_pulses++; rst_width++; if (rst_width > rst_wmax) rst_wmax = rst_width; end
         else rst_width = 0;
         if (rreq && irq && !irq_prev) both_seen = 1;
         irq_prev = irq;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000) begin
         checks++; errors++;
         $display("FAIL watchdog: run hung, got cycle %0d exp finish", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // ---------------- tasks ----------------
   task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
      checks++;
      if (act !== exp) begin
         errors++; $display("FAIL %s: got 0x%0h exp 0x%0h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); en = 1; we = 1; addr = a; wdata = d;
      @(negedge clk); en = 0; we = 0;
   endtask

   // reads the register and compares to both a fixed value and the model
   task automatic bus_rd(input string tag, input logic [3:0] a, input int unsigned exp);
      @(negedge clk); en = 1; we = 0; addr = a;
      #1;
      chk(tag, rdata, exp);
      chk({tag, " model"}, rdata, model_read(a));
      en = 0;
   endtask

   task automatic bus_rd_model(input string tag, input logic [3:0] a);
      @(negedge clk); en = 1; we = 0; addr = a;
      #1;
      chk(tag, rdata, model_read(a));
      en = 0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      wait_cyc(4);
      @(negedge clk); rst_n = 1;

      // R1 reset values
      chk("R1 irq_o", irq, 0);
      chk("R1 sys_rst_req_o", rreq, 0);
      bus_rd("R1 ctrl", 4'h0, 0);
      bus_rd("R1 reload", 4'h4, 32'h8000);
      bus_rd("R1 count", 4'h8, 32'h8000);

      // R2 field layout and masking
      bus_wr(4'h0, 32'hFFFF_FFFF);
      bus_rd("R2 ctrl mask", 4'h0, 32'h0000_FF3D);
      bus_wr(4'h0, 32'h0);
      bus_wr(4'h4, 32'hABCD_1234);
      bus_rd("R2 reload low half", 4'h4, 32'h1234);
      bus_wr(4'h8, 32'h5555_0007);
      bus_rd("R2 count low half", 4'h8, 32'h0007);

      // R3 period 16 with prescale 0, div 0: 41 edges after start -> 2 ticks
      bus_wr(4'h8, 10);
      bus_wr(4'h0, 32'h20);
      wait_cyc(40);
      bus_rd("R3 count after two ticks", 4'h8, 8);

      // R10 stop freezes and resets the prescaler phase
      bus_wr(4'h0, 32'h0);
      bus_rd("R10 count at stop", 4'h8, 8);
      wait_cyc(100);
      bus_rd("R10 count frozen", 4'h8, 8);
      bus_wr(4'h0, 32'h20);
      wait_cyc(13);
      bus_rd("R10 no early tick after restart", 4'h8, 8);
      wait_cyc(1);
      bus_rd("R3 first tick after full period", 4'h8, 7);
      bus_wr(4'h0, 32'h0);

      // R4 / R5 expiry with interrupt
      bus_wr(4'h4, 1);
      bus_wr(4'h8, 1);
      bus_wr(4'h0, 32'h24);
      wait_cyc(38);
      chk("R5 irq set after expiry", irq, 1);
      bus_rd("R4 count reloaded", 4'h8, 1);
      wait_cyc(30);
      chk("R5 irq stays high", irq, 1);
      bus_rd("R9 clear register reads zero", 4'hC, 0);
      bus_wr(4'hC, 32'h0);
      chk("R5 irq cleared by write", irq, 0);
      bus_wr(4'h0, 32'h0);

      // R8 keepalive holds off expiry
      bus_wr(4'h8, 3);
      bus_wr(4'h0, 32'h24);
      for (int i = 0; i < 10; i++) begin
         wait_cyc(28);
         bus_wr(4'h8, 3);
      end
      chk("R8 no expiry under keepalive", irq, 0);
      bus_wr(4'h0, 32'h0);

      // R6 reset pulses: reload 2 -> expiry every 48 cycles
      bus_wr(4'h4, 2);
      bus_wr(4'h8, 2);
      rst_pulses = 0; rst_wmax = 0;
      bus_wr(4'h0, 32'h21);
      wait_cyc(149);
      chk("R6 pulse count", rst_pulses, 3);
      chk("R6 pulse width", rst_wmax, 1);
      bus_wr(4'h0, 32'h0);

      // R7 both enables fire together
      bus_wr(4'h4, 0);
      bus_wr(4'h8, 0);
      both_seen = 0;
      bus_wr(4'h0, 32'h25);
      wait_cyc(24);
      chk("R7 irq and reset same cycle", both_seen, 1);
      bus_wr(4'h0, 32'h0);
      bus_wr(4'hC, 32'hFFFF_FFFF);
      chk("R5 clear with any data", irq, 0);

      // R12 no enables: reload only
      bus_wr(4'h4, 5);
      bus_wr(4'h8, 0);
      rst_pulses = 0;
      bus_wr(4'h0, 32'h20);
      wait_cyc(49);
      bus_rd("R12 count reloaded and running", 4'h8, 3);
      chk("R12 irq quiet", irq, 0);
      chk("R12 reset quiet", rst_pulses, 0);
      bus_wr(4'h0, 32'h0);

      // R11 settings change while running (prescale 3, div select 1)
      bus_wr(4'h8, 20);
      bus_wr(4'h0, 32'h0328);
      wait_cyc(70);
      bus_wr(4'h0, 32'h0020);
      wait_cyc(30);
      bus_rd_model("R11 count after mid-run change", 4'h8);
      wait_cyc(50);
      bus_rd_model("R11 count later", 4'h8);
      bus_wr(4'h0, 32'h0120);
      wait_cyc(37);
      bus_rd_model("R11 count after prescale 1", 4'h8);
      bus_wr(4'h0, 32'h0);

      wait_cyc(4);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule